// File: doc/BRIEF.md
# Read-Back Byte Sequencer

This block supplies the bytes a serial-bus slave returns during a read transaction. The bus front end handles line shifting and address matching. Once it has acknowledged its own address with the read bit set, it pulses a start strobe. At that moment the sequencer takes a snapshot of the stored data word and of the last control byte. Each time the front end needs a byte for its shift register, it pulses a request strobe. The sequencer answers on the next cycle with a registered byte and a valid flag.

The order of the returned bytes is fixed. The upper half of the data word comes first, then the lower half, then the control byte. A master acknowledge after the control byte wraps the order back to the upper data byte. The front end reports the master's acknowledge bit with a strobe and a not-acknowledge flag. An acknowledge moves the sequencer to the next byte. A not-acknowledge ends the read. A start or stop condition seen on the bus returns the sequencer to idle from any state. When the returned control byte has bits 5, 4 and 2 all clear, the two data bytes that came before it are the temporary register contents. The sequencer returns the snapshot unchanged in every case.

Top module: `rbReadSeq`

## Requirements
- R1: After reset, txValid is 0 and the sequencer is idle: a byteReq pulse before any rdStart leaves txValid at 0.
- R2: A rdStart pulse captures storedData and ctrlByte. Later changes to those inputs do not change any byte returned during that read.
- R3: After rdStart, the first byteReq makes txValid 1 on the next cycle, with txByte equal to storedData[15:8] as captured.
- R4: After a master acknowledge (ackValid=1, ackNack=0), the next byteReq returns storedData[7:0]. After a further acknowledge, the next byteReq returns the captured control byte.
- R5: A master acknowledge of the control byte makes the next byteReq return the upper data byte again, so the order repeats with period three.
- R6: A not-acknowledge (ackValid=1, ackNack=1) while a byte is presented clears txValid on the next cycle. Every later byteReq is ignored until a new rdStart.
- R7: busCond=1 clears txValid on the next cycle and returns the sequencer to idle. It takes priority over every other input in the same cycle.
- R8: While a byte is presented, txValid and txByte hold until ackValid, busCond or rdStart arrives. A byteReq in that window is ignored.
- R9: An ackValid pulse while no byte is presented has no effect: the next byteReq returns the byte that was next before the pulse.
- R10: A rdStart during a read restarts the sequence. txValid clears on the next cycle, a fresh snapshot is taken, and the next byteReq returns the new upper data byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busCond | input | 1 | Pulse: start or stop condition detected on the bus |
| rdStart | input | 1 | Pulse: own address with read bit acknowledged |
| byteReq | input | 1 | Pulse: front end needs the next byte to shift out |
| ackValid | input | 1 | Pulse: master acknowledge bit has been sampled |
| ackNack | input | 1 | Qualifies ackValid: 1 means not-acknowledge |
| storedData | input | 16 | Current stored data word |
| ctrlByte | input | 8 | Last control byte received |
| txByte | output | 8 | Byte to transmit |
| txValid | output | 1 | txByte is presented and awaits the master's acknowledge bit |

## Verification
The bound assertions check the local rules on every cycle:
- txValid only rises the cycle after a byteReq.
- The first byte after a start equals the upper data byte latched at that start.
- A presented byte holds steady until an acknowledge, start or bus condition.
- A not-acknowledge, a bus condition or a restart always drops txValid.

Only the bench's scenarios show the longer-range behaviour: the three-byte order and its wrap, the immunity of a read to data changes made after the start, and the fact that stray acknowledges and requests leave the byte position untouched.

// File: rtl/rbSeqPkg.sv
package rbSeqPkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_READY   = 2'd1,
    ST_PRESENT = 2'd2
  } seqState_e;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic capture;  // take a snapshot of data word and control byte
    logic load;     // drive the selected slot onto txByte, raise valid
    logic clear;    // drop valid
  } seqStrobe_t;

endpackage

// File: rtl/rbSeqCtrl.sv
module rbSeqCtrl
  import rbSeqPkg::*;
#(
  parameter int SEQ_LEN = 3,
  localparam int SEL_W  = (SEQ_LEN > 1) ? $clog2(SEQ_LEN) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busCond,
  input  logic             rdStart,
  input  logic             byteReq,
  input  logic             ackValid,
  input  logic             ackNack,
  output seqStrobe_t       strobe,
  output logic [SEL_W-1:0] slotSel
);

  localparam logic [SEL_W-1:0] LAST_SLOT = SEL_W'(SEQ_LEN - 1);

  seqState_e        state, stateNext;
  logic [SEL_W-1:0] idx, idxNext;

  always_comb begin
    stateNext = state;
    idxNext   = idx;
    strobe    = '0;
    if (busCond) begin
      stateNext    = ST_IDLE;
      strobe.clear = 1'b1;
    end else if (rdStart) begin
      stateNext      = ST_READY;
      idxNext        = '0;
      strobe.capture = 1'b1;
      strobe.clear   = 1'b1;
    end else begin
      unique case (state)
        ST_READY: begin
          if (byteReq) begin
            strobe.load = 1'b1;
            stateNext   = ST_PRESENT;
          end
        end
        ST_PRESENT: begin
          if (ackValid) begin
            strobe.clear = 1'b1;
            if (ackNack) begin
              stateNext = ST_IDLE;
            end else begin
              stateNext = ST_READY;
              idxNext   = (idx == LAST_SLOT) ? '0 : idx + 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      idx   <= '0;
    end else begin
      state <= stateNext;
      idx   <= idxNext;
    end
  end

  assign slotSel = idx;

endmodule

// File: rtl/rbSeqData.sv
module rbSeqData
  import rbSeqPkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int BYTE_W  = 8,
  localparam int NUM_DATA = DATA_W / BYTE_W,
  localparam int SEQ_LEN  = NUM_DATA + 1,
  localparam int SEL_W    = (SEQ_LEN > 1) ? $clog2(SEQ_LEN) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [SEL_W-1:0]  slotSel,
  input  logic [DATA_W-1:0] storedData,
  input  logic [BYTE_W-1:0] ctrlByte,
  output logic [BYTE_W-1:0] txByte,
  output logic              txValid
);

  logic [SEQ_LEN-1:0][BYTE_W-1:0] slotD, slotQ;
  logic [BYTE_W-1:0]              pick;

  // data bytes most significant first, control byte in the last slot
  for (genvar g = 0; g < NUM_DATA; g++) begin : gDataSlot
    assign slotD[g] = storedData[DATA_W-1-g*BYTE_W -: BYTE_W];
  end
  assign slotD[SEQ_LEN-1] = ctrlByte;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotQ <= '0;
    end else if (strobe.capture) begin
      slotQ <= slotD;
    end
  end

  always_comb begin
    pick = '0;
    for (int i = 0; i < SEQ_LEN; i++) begin
      if (slotSel == SEL_W'(i)) pick = slotQ[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txByte  <= '0;
      txValid <= 1'b0;
    end else if (strobe.load) begin
      txByte  <= pick;
      txValid <= 1'b1;
    end else if (strobe.clear) begin
      txValid <= 1'b0;
    end
  end

endmodule

// File: rtl/rbReadSeq.sv
module rbReadSeq
  import rbSeqPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busCond,
  input  logic              rdStart,
  input  logic              byteReq,
  input  logic              ackValid,
  input  logic              ackNack,
  input  logic [DATA_W-1:0] storedData,
  input  logic [BYTE_W-1:0] ctrlByte,
  output logic [BYTE_W-1:0] txByte,
  output logic              txValid
);

  localparam int SEQ_LEN = DATA_W / BYTE_W + 1;
  localparam int SEL_W   = (SEQ_LEN > 1) ? $clog2(SEQ_LEN) : 1;

  seqStrobe_t       strobe;
  logic [SEL_W-1:0] slotSel;

  rbSeqCtrl #(.SEQ_LEN(SEQ_LEN)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .busCond  (busCond),
    .rdStart  (rdStart),
    .byteReq  (byteReq),
    .ackValid (ackValid),
    .ackNack  (ackNack),
    .strobe   (strobe),
    .slotSel  (slotSel)
  );

  rbSeqData #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) uData (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .slotSel    (slotSel),
    .storedData (storedData),
    .ctrlByte   (ctrlByte),
    .txByte     (txByte),
    .txValid    (txValid)
  );

endmodule

// File: rtl/rbReadSeqChk.sv
module rbReadSeqChk #(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              busCond,
  input logic              rdStart,
  input logic              byteReq,
  input logic              ackValid,
  input logic              ackNack,
  input logic [DATA_W-1:0] storedData,
  input logic [BYTE_W-1:0] ctrlByte,
  input logic [BYTE_W-1:0] txByte,
  input logic              txValid
);

  logic              firstPend;
  logic [BYTE_W-1:0] expMs;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      firstPend <= 1'b0;
      expMs     <= '0;
    end else if (busCond) begin
      firstPend <= 1'b0;
    end else if (rdStart) begin
      firstPend <= 1'b1;
      expMs     <= storedData[DATA_W-1 -: BYTE_W];
    end else if (txValid) begin
      firstPend <= 1'b0;
    end
  end

  AST_LOAD_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txValid) |-> $past(byteReq)); // R3

  AST_FIRST_IS_MS: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(txValid) && firstPend) |-> (txByte == expMs)); // R3

  AST_NACK_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    (ackValid && ackNack && txValid) |=> !txValid); // R6

  AST_BUS_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    busCond |=> !txValid); // R7

  AST_HOLD_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !ackValid && !busCond && !rdStart) |=> (txValid && $stable(txByte))); // R8

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    rdStart |=> !txValid); // R10

endmodule

bind rbReadSeq rbReadSeqChk #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) uChk (.*);

// File: tb/rbReadSeq_bench.sv
`timescale 1ns/1ps
module rbReadSeq_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busCond = 1'b0;
  logic        rdStart = 1'b0;
  logic        byteReq = 1'b0;
  logic        ackValid = 1'b0;
  logic        ackNack = 1'b0;
  logic [15:0] storedData = '0;
  logic [7:0]  ctrlByte = '0;
  logic [7:0]  txByte;
  logic        txValid;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // behavioural reference
  int       mState = 0;   // 0 idle, 1 ready, 2 presenting
  int       mIdx = 0;
  byte      mQ[$];
  bit       mValid = 1'b0;
  logic [7:0] mByte = '0;

  always #2 clk = ~clk;

  rbReadSeq u_rbReadSeq (
    .clk(clk), .rstN(rstN), .busCond(busCond), .rdStart(rdStart),
    .byteReq(byteReq), .ackValid(ackValid), .ackNack(ackNack),
    .storedData(storedData), .ctrlByte(ctrlByte),
    .txByte(txByte), .txValid(txValid)
  );

  task automatic modelStep();
    if (!rstN) begin
      mState = 0; mIdx = 0; mValid = 1'b0; mQ.delete();
    end else if (busCond) begin
      mState = 0; mValid = 1'b0;
    end else if (rdStart) begin
      mQ.delete();
      mQ.push_back(storedData[15:8]);
      mQ.push_back(storedData[7:0]);
      mQ.push_back(ctrlByte);
      mIdx = 0; mState = 1; mValid = 1'b0;
    end else if (mState == 1 && byteReq) begin
      mByte = mQ[mIdx]; mValid = 1'b1; mState = 2;
    end else if (mState == 2 && ackValid) begin
      mValid = 1'b0;
      if (ackNack) mState = 0;
      else begin mIdx = (mIdx + 1) % 3; mState = 1; end
    end
  endtask

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock: model at the edge, compare at the falling edge
  task automatic step(string tag);
    @(posedge clk);
    modelStep();
    @(negedge clk);
    check(tag, {7'd0, txValid}, {7'd0, mValid});
    if (mValid) check(tag, txByte, mByte);
  endtask

  task automatic pulse(string tag, bit bc, bit rs, bit br, bit av, bit nk);
    busCond = bc; rdStart = rs; byteReq = br; ackValid = av; ackNack = nk;
    step(tag);
    busCond = 0; rdStart = 0; byteReq = 0; ackValid = 0; ackNack = 0;
    step(tag);
  endtask

  task automatic expectByte(string tag, logic [7:0] exp);
    checks++;
    if (!txValid || txByte !== exp) begin
      failures++;
      $display("FAIL %s actual=%h/%0b expected=%h/1", tag, txByte, txValid, exp);
    end
  endtask

  initial begin
    @(negedge clk);
    step("R1"); step("R1");
    rstN = 1'b1;
    step("R1");
    pulse("R1", 0, 0, 1, 0, 0);        // request while idle: ignored
    pulse("R1", 0, 0, 0, 1, 0);

    // full read with wrap
    storedData = 16'hA5C3; ctrlByte = 8'h01;
    pulse("R2", 0, 1, 0, 0, 0);
    storedData = 16'h1234; ctrlByte = 8'h30;  // must not be seen
    pulse("R3", 0, 0, 1, 0, 0);
    expectByte("R3", 8'hA5);
    pulse("R4", 0, 0, 0, 1, 0);
    pulse("R4", 0, 0, 1, 0, 0);
    expectByte("R4", 8'hC3);
    pulse("R4", 0, 0, 0, 1, 0);
    pulse("R4", 0, 0, 1, 0, 0);
    expectByte("R2", 8'h01);
    pulse("R5", 0, 0, 0, 1, 0);
    pulse("R5", 0, 0, 1, 0, 0);
    expectByte("R5", 8'hA5);
    pulse("R8", 0, 0, 1, 0, 0);          // extra request while presenting
    expectByte("R8", 8'hA5);
    pulse("R6", 0, 0, 0, 1, 1);
    pulse("R6", 0, 0, 1, 0, 0);
    pulse("R6", 0, 0, 0, 1, 0);

    // stray ack while ready
    storedData = 16'h5A3C; ctrlByte = 8'h00;
    pulse("R9", 0, 1, 0, 0, 0);
    pulse("R9", 0, 0, 0, 1, 0);
    pulse("R9", 0, 0, 1, 0, 0);
    expectByte("R9", 8'h5A);
    pulse("R9", 0, 0, 0, 1, 0);
    pulse("R9", 0, 0, 0, 1, 1);          // nack while nothing presented
    pulse("R9", 0, 0, 1, 0, 0);
    expectByte("R9", 8'h3C);

    // bus condition wins over everything
    pulse("R7", 1, 1, 1, 1, 0);
    pulse("R7", 0, 0, 1, 0, 0);
    pulse("R7", 0, 1, 0, 0, 0);
    pulse("R7", 0, 0, 1, 0, 0);
    pulse("R7", 1, 0, 0, 0, 0);
    pulse("R7", 0, 0, 1, 0, 0);

    // restart mid read picks up new data
    storedData = 16'hBEEF; ctrlByte = 8'h11;
    pulse("R10", 0, 1, 0, 0, 0);
    pulse("R10", 0, 0, 1, 0, 0);
    pulse("R10", 0, 0, 0, 1, 0);
    storedData = 16'hCAFE; ctrlByte = 8'h34;
    pulse("R10", 0, 1, 1, 0, 0);
    pulse("R10", 0, 0, 1, 0, 0);
    expectByte("R10", 8'hCA);
    pulse("R10", 0, 0, 0, 1, 0);
    pulse("R10", 0, 0, 1, 0, 0);
    pulse("R10", 0, 0, 0, 1, 0);
    pulse("R10", 0, 0, 1, 0, 0);
    expectByte("R10", 8'h34);

    // back-to-back pulses on adjacent cycles
    byteReq = 1; step("R8");
    ackValid = 1; step("R8");
    byteReq = 0; step("R8");
    ackValid = 0; step("R8");
    step("R8");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule